// File: doc/BRIEF.md
# EDO DRAM Cycle Decoder Model

This block is a synthesizable, clock-sampled model of the control side of a 4-bit-wide EDO DRAM. It is meant to stand in for the memory part when a memory controller is being tested. Every clock it samples the row strobe, column strobe, write enable, output enable and the multiplexed address bus. From the order of the strobe edges and the level of write enable, it works out which kind of cycle each row-strobe-low period was.

The cycle kinds are read, early write, read-modify-write, row-only refresh, column-before-row refresh, hidden refresh, self-refresh and test-mode entry. The block keeps its own refresh row counter. This counter is 12 bits wide in the 4k-refresh variant and 11 bits wide in the 2k-refresh variant. It also holds a small array of 4-bit words, so that data can be written and read back. It drives the data bus with an enable, and it releases the bus in the way the part would.

When the row strobe rises, the block puts the decoded cycle kind and the row used on a report port. A scoreboard compares these against its own expectations. Timing in nanoseconds is outside the model; only the order of events matters.

Top module: `edo_cycle_decoder`

## Requirements
- R1: After reset, `dq_oe`, `cyc_valid`, `self_ref` and `proto_err` are 0, `dq_out` is 0 and the refresh counter is 0.
- R2: A column strobe fall with write enable high, while the row strobe is low, reads a word. The word is selected by the low MEM_ROW_BITS of the row latched at the row strobe fall and the low MEM_COL_BITS of the address at the column strobe fall. `dq_oe` is 1 from the next cycle while `oe_n` is low. The data stays driven after the column strobe rises while the row strobe is still low. The bus turns off one cycle after both strobes are sampled high. The cycle is reported as code 1.
- R3: If write enable is low at the column strobe fall, the cycle is an early write. It stores `dq_in` into the selected word. The bus is not driven in that cycle, and the cycle is reported as code 2.
- R4: If write enable falls during a read with the column strobe low and read data driven, the cycle is a read-modify-write. It stores `dq_in` into the word read, and the cycle is reported as code 3.
- R5: A row strobe period with no column strobe fall is a row-only refresh. It is reported as code 4, with the row taken from the address at the row strobe fall, and the bus stays off.
- R6: If the column strobe is already low when the row strobe falls and write enable is high, the cycle is a column-before-row refresh. It is reported as code 5. The reported row is the counter value, and the address pins have no effect on it. The counter then increments by one, wrapping at 2^12 (4k variant) or 2^11 (2k variant).
- R7: A column-before-row cycle with write enable low at the row strobe fall is a test-mode entry. It is reported as code 8, and the counter does not advance.
- R8: If the column strobe is held low from an access through a row strobe rise and a new fall, the cycle is a hidden refresh. It is reported as code 6 and uses and advances the counter. The read data stays driven throughout.
- R9: Raising `oe_n` turns the bus off in the same cycle. Lowering it again while read data is held turns the bus back on.
- R10: `self_ref` rises once the row strobe has stayed low in a column-before-row cycle for SELF_REF_CYCLES clocks. It clears on the row strobe rise, and such a cycle is reported as code 7.
- R11: `proto_err` pulses with the report when, outside column-before-row cycles, the address changed more than once while the row strobe was low and the column strobe fell fewer than twice (not page mode).
- R12: `cyc_valid` is a single-cycle pulse that appears in the cycle after the row strobe rise is sampled, together with `cyc_type` and `cyc_row`. Code 0 is never reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ROW_W | Multiplexed row/column address (12 bits in the 4k variant, 11 in the 2k variant) |
| dq_in | input | DQ_W | Write data from the controller |
| dq_out | output | DQ_W | Read data, 0 when not driven |
| dq_oe | output | 1 | Data bus drive enable |
| cyc_valid | output | 1 | Report strobe |
| cyc_type | output | 4 | Decoded cycle code |
| cyc_row | output | ROW_W | Row accessed or refreshed |
| self_ref | output | 1 | Device is in self-refresh |
| proto_err | output | 1 | Address-change ordering violation |

## Verification
The decoder is driven with the strobe orderings of each cycle kind. Column strobe after the row strobe, with write enable high, low, or falling late, separates read, early write and read-modify-write. A missing column strobe gives row-only refresh. Column strobe before the row strobe, with write enable high or low, separates refresh from test entry, and long holds separate refresh from self-refresh. A column strobe held across two row strobe periods separates hidden refresh from a plain refresh. Page mode and a doubled address change separate legal from illegal address activity, and aliasing rows check which address bits select a word.

// File: rtl/edo_dec_pkg.sv
package edo_dec_pkg;

   typedef enum logic [3:0] {
      CYC_NONE   = 4'd0,
      CYC_READ   = 4'd1,
      CYC_WRITE  = 4'd2,
      CYC_RMW    = 4'd3,
      CYC_ROR    = 4'd4,
      CYC_CBR    = 4'd5,
      CYC_HIDDEN = 4'd6,
      CYC_SELF   = 4'd7,
      CYC_TEST   = 4'd8
   } cyc_e;

   typedef struct packed {
      logic ras_fall;
      logic ras_rise;
      logic cas_fall;
      logic we_fall;
      logic addr_moved;
   } strobe_ev_t;

endpackage

// File: rtl/edo_strobe_edges.sv
module edo_strobe_edges import edo_dec_pkg::*; #(
   parameter int AW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ras_n,
   input  logic          cas_n,
   input  logic          we_n,
   input  logic [AW-1:0] addr,
   output strobe_ev_t    ev
);

   logic          ras_q, cas_q, we_q;
   logic [AW-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ras_q  <= 1'b1;
         cas_q  <= 1'b1;
         we_q   <= 1'b1;
         addr_q <= '0;
      end else begin
         ras_q  <= ras_n;
         cas_q  <= cas_n;
         we_q   <= we_n;
         addr_q <= addr;
      end
   end

   always_comb begin
      ev.ras_fall   = ras_q & ~ras_n;
      ev.ras_rise   = ~ras_q & ras_n;
      ev.cas_fall   = cas_q & ~cas_n;
      ev.we_fall    = we_q & ~we_n;
      ev.addr_moved = ~ras_q & ~ras_n & (addr != addr_q);
   end

endmodule

// File: rtl/edo_refresh_ctr.sv
module edo_refresh_ctr #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         adv,
   output logic [W-1:0] row
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   row <= '0;
      else if (adv) row <= row + 1'b1;
   end

endmodule

// File: rtl/edo_word_array.sv
module edo_word_array #(
   parameter int AW = 6,
   parameter int DW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data
);

   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] words [DEPTH];

   for (genvar w = 0; w < DEPTH; w++) begin : g_word
      logic [DW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (wr_en && wr_addr == AW'(w))
            q <= wr_data;
      end
      assign words[w] = q;
   end

   assign rd_data = words[rd_addr];

endmodule

// File: rtl/edo_cycle_decoder.sv
module edo_cycle_decoder import edo_dec_pkg::*; #(
   parameter bit REFRESH_4K      = 1'b1,
   parameter int MEM_ROW_BITS    = 3,
   parameter int MEM_COL_BITS    = 3,
   parameter int SELF_REF_CYCLES = 1024,
   parameter int DQ_W            = 4,
   localparam int ROW_W          = REFRESH_4K ? 12 : 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ras_n,
   input  logic             cas_n,
   input  logic             we_n,
   input  logic             oe_n,
   input  logic [ROW_W-1:0] addr,
   input  logic [DQ_W-1:0]  dq_in,
   output logic [DQ_W-1:0]  dq_out,
   output logic             dq_oe,
   output logic             cyc_valid,
   output logic [3:0]       cyc_type,
   output logic [ROW_W-1:0] cyc_row,
   output logic             self_ref,
   output logic             proto_err
);

   localparam int COL_W  = REFRESH_4K ? 10 : 11;
   localparam int MEM_AW = MEM_ROW_BITS + MEM_COL_BITS;
   localparam int SC_W   = $clog2(SELF_REF_CYCLES) + 1;

   if (MEM_ROW_BITS < 1 || MEM_ROW_BITS > ROW_W) begin : g_bad_row
      $error("MEM_ROW_BITS must lie in 1..ROW_W");
   end
   if (MEM_COL_BITS < 1 || MEM_COL_BITS > COL_W) begin : g_bad_col
      $error("MEM_COL_BITS must lie in 1..COL_W");
   end
   if (MEM_AW > 10) begin : g_bad_depth
      $error("word array too deep for a model");
   end
   if (SELF_REF_CYCLES < 2) begin : g_bad_self
      $error("SELF_REF_CYCLES must be at least 2");
   end

   // ---------------- edge detection ----------------
   strobe_ev_t ev;

   edo_strobe_edges #(.AW(ROW_W)) u_edges (
      .clk   (clk),
      .rst_n (rst_n),
      .ras_n (ras_n),
      .cas_n (cas_n),
      .we_n  (we_n),
      .addr  (addr),
      .ev    (ev)
   );

   // ---------------- refresh counter (variant) ----------------
   logic             ref_adv;
   logic [ROW_W-1:0] ref_row;

   assign ref_adv = ev.ras_fall & ~cas_n & we_n;

   if (REFRESH_4K) begin : g_ctr_4k
      edo_refresh_ctr #(.W(12)) u_ctr (
         .clk(clk), .rst_n(rst_n), .adv(ref_adv), .row(ref_row)
      );
   end else begin : g_ctr_2k
      edo_refresh_ctr #(.W(11)) u_ctr (
         .clk(clk), .rst_n(rst_n), .adv(ref_adv), .row(ref_row)
      );
   end

   // ---------------- per-period state ----------------
   logic                    in_cbr, is_test, is_hidden;
   logic [ROW_W-1:0]        row_q;
   logic [MEM_COL_BITS-1:0] col_q;
   logic [1:0]              cas_cnt, chg_cnt;
   logic                    wr_seen, rmw_seen;
   logic [SC_W-1:0]         self_cnt;
   logic                    rd_valid, cas_acc;
   logic [DQ_W-1:0]         rd_data;

   logic access_fall, rmw_wr, mem_we;
   logic [MEM_AW-1:0] mem_waddr, mem_raddr;
   logic [DQ_W-1:0]   mem_rdata;
   cyc_e              next_type;

   assign access_fall = ev.cas_fall & ~ras_n & ~ev.ras_fall & ~in_cbr;
   assign rmw_wr      = ev.we_fall & ~ev.cas_fall & ~cas_n & ~ras_n
                        & ~in_cbr & rd_valid;
   assign mem_we      = (access_fall & ~we_n) | rmw_wr;
   assign mem_raddr   = {row_q[MEM_ROW_BITS-1:0], addr[MEM_COL_BITS-1:0]};
   assign mem_waddr   = rmw_wr ? {row_q[MEM_ROW_BITS-1:0], col_q} : mem_raddr;

   edo_word_array #(.AW(MEM_AW), .DW(DQ_W)) u_array (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (mem_we),
      .wr_addr (mem_waddr),
      .wr_data (dq_in),
      .rd_addr (mem_raddr),
      .rd_data (mem_rdata)
   );

   always_comb begin
      if (in_cbr) begin
         if (is_test)        next_type = CYC_TEST;
         else if (is_hidden) next_type = CYC_HIDDEN;
         else if (self_ref)  next_type = CYC_SELF;
         else                next_type = CYC_CBR;
      end else begin
         if (cas_cnt == 2'd0) next_type = CYC_ROR;
         else if (rmw_seen)   next_type = CYC_RMW;
         else if (wr_seen)    next_type = CYC_WRITE;
         else                 next_type = CYC_READ;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_cbr    <= 1'b0;
         is_test   <= 1'b0;
         is_hidden <= 1'b0;
         row_q     <= '0;
         col_q     <= '0;
         cas_cnt   <= '0;
         chg_cnt   <= '0;
         wr_seen   <= 1'b0;
         rmw_seen  <= 1'b0;
         self_cnt  <= '0;
         self_ref  <= 1'b0;
         cyc_valid <= 1'b0;
         cyc_type  <= CYC_NONE;
         cyc_row   <= '0;
         proto_err <= 1'b0;
      end else begin
         cyc_valid <= 1'b0;
         proto_err <= 1'b0;
         if (ev.ras_fall) begin
            in_cbr    <= ~cas_n;
            is_test   <= ~cas_n & ~we_n;
            is_hidden <= ~cas_n & cas_acc;
            row_q     <= cas_n ? addr : ref_row;
            cas_cnt   <= '0;
            chg_cnt   <= '0;
            wr_seen   <= 1'b0;
            rmw_seen  <= 1'b0;
            self_cnt  <= '0;
            self_ref  <= 1'b0;
         end else if (!ras_n) begin
            if (ev.addr_moved && chg_cnt != 2'd3)
               chg_cnt <= chg_cnt + 2'd1;
            if (access_fall) begin
               col_q <= addr[MEM_COL_BITS-1:0];
               if (cas_cnt != 2'd3) cas_cnt <= cas_cnt + 2'd1;
               if (!we_n) wr_seen <= 1'b1;
            end
            if (rmw_wr) rmw_seen <= 1'b1;
            if (in_cbr && !is_test && !self_ref) begin
               self_cnt <= self_cnt + 1'b1;
               if (self_cnt == SC_W'(SELF_REF_CYCLES - 1)) self_ref <= 1'b1;
            end
         end
         if (ev.ras_rise) begin
            cyc_valid <= 1'b1;
            cyc_type  <= next_type;
            cyc_row   <= row_q;
            proto_err <= ~in_cbr & (chg_cnt > 2'd1) & (cas_cnt < 2'd2);
            self_ref  <= 1'b0;
         end
      end
   end

   // ---------------- data bus ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
         cas_acc  <= 1'b0;
      end else begin
         if (ras_n && cas_n)
            rd_valid <= 1'b0;
         else if (access_fall) begin
            rd_valid <= we_n;
            if (we_n) rd_data <= mem_rdata;
         end
         if (cas_n)            cas_acc <= 1'b0;
         else if (access_fall) cas_acc <= 1'b1;
      end
   end

   assign dq_oe  = rd_valid & ~oe_n;
   assign dq_out = dq_oe ? rd_data : '0;

endmodule

// File: rtl/edo_cycle_decoder_chk.sv
module edo_cycle_decoder_chk import edo_dec_pkg::*; #(
   parameter int ROW_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ras_n,
   input logic             cas_n,
   input logic             we_n,
   input logic             oe_n,
   input logic             dq_oe,
   input logic             cyc_valid,
   input logic [3:0]       cyc_type,
   input logic [ROW_W-1:0] cyc_row,
   input logic             self_ref
);

   logic             have_ref;
   logic [ROW_W-1:0] last_ref;
   logic             ref_kind;

   assign ref_kind = cyc_valid && (cyc_type == CYC_CBR || cyc_type == CYC_HIDDEN
                                   || cyc_type == CYC_SELF);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         have_ref <= 1'b0;
         last_ref <= '0;
      end else if (ref_kind) begin
         have_ref <= 1'b1;
         last_ref <= cyc_row;
      end
   end

   AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (!ras_n && !$fell(ras_n) && $fell(cas_n) && !we_n) |=> !dq_oe); // R3

   AST_BUS_OFF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dq_oe) |-> (oe_n || $past(ras_n && cas_n) || $past(!we_n))); // R2

   AST_ROR_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_valid && cyc_type == CYC_ROR) |-> !dq_oe); // R5

   AST_REF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_kind && have_ref) |-> (cyc_row == last_ref + 1'b1)); // R6

   AST_SELF_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ras_n) |=> !self_ref); // R10

   AST_REPORT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_valid |=> !cyc_valid); // R12

   AST_NO_NONE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_valid |-> cyc_type != CYC_NONE); // R12

endmodule

bind edo_cycle_decoder edo_cycle_decoder_chk #(.ROW_W(ROW_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ras_n     (ras_n),
   .cas_n     (cas_n),
   .we_n      (we_n),
   .oe_n      (oe_n),
   .dq_oe     (dq_oe),
   .cyc_valid (cyc_valid),
   .cyc_type  (cyc_type),
   .cyc_row   (cyc_row),
   .self_ref  (self_ref)
);

// File: tb/edo_cycle_decoder_tb_top.sv
`timescale 1ns/1ps
module edo_cycle_decoder_tb_top;

   localparam int SELF_THR = 16;

   localparam logic [3:0] T_READ = 4'd1, T_WRITE = 4'd2, T_RMW = 4'd3, T_ROR = 4'd4,
                          T_CBR = 4'd5, T_HIDDEN = 4'd6, T_SELF = 4'd7, T_TEST = 4'd8;

   localparam logic [2:0] OP_ROR = 3'd0, OP_WR = 3'd1, OP_RD = 3'd2, OP_RMW = 3'd3,
                          OP_CBR = 3'd4, OP_TEST = 3'd5;

   typedef struct packed {
      logic [2:0]  op;
      logic [11:0] row;
      logic [11:0] col;
      logic [3:0]  data;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      '{OP_WR,   12'h005, 12'h003, 4'hA},
      '{OP_RD,   12'h005, 12'h003, 4'h0},
      '{OP_ROR,  12'h7FF, 12'h000, 4'h0},
      '{OP_CBR,  12'hABC, 12'h123, 4'h0},
      '{OP_WR,   12'h8F2, 12'h3F7, 4'h5},
      '{OP_RMW,  12'h005, 12'h003, 4'h6},
      '{OP_RD,   12'h005, 12'h003, 4'h0},
      '{OP_TEST, 12'h000, 12'h000, 4'h0},
      '{OP_CBR,  12'h555, 12'h2AA, 4'h0},
      '{OP_RD,   12'hE0D, 12'h013, 4'h0},
      '{OP_RD,   12'h00A, 12'h007, 4'h0},
      '{OP_CBR,  12'h000, 12'hFFF, 4'h0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
   logic [11:0] addr = '0;
   logic [3:0]  dq_in = '0;
   logic [3:0]  dq_out;
   logic        dq_oe, cyc_valid, self_ref, proto_err;
   logic [3:0]  cyc_type;
   logic [11:0] cyc_row;

   int n_chk = 0;
   int n_err = 0;
   logic [3:0]  mdl [64];
   logic [11:0] ref_ctr = '0;
   logic        done = 1'b0;

   always #2 clk = ~clk;

   edo_cycle_decoder #(.SELF_REF_CYCLES(SELF_THR)) dut_i (
      .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
      .cyc_valid(cyc_valid), .cyc_type(cyc_type), .cyc_row(cyc_row),
      .self_ref(self_ref), .proto_err(proto_err)
   );

   function automatic int widx(input logic [11:0] r, input logic [11:0] c);
      return int'({r[2:0], c[2:0]});
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic report(input string req, input logic [3:0] t, input logic [11:0] r,
                         input logic perr);
      chk(req, "cyc_valid", 32'(cyc_valid), 32'd1);
      chk(req, "cyc_type", 32'(cyc_type), 32'(t));
      chk(req, "cyc_row", 32'(cyc_row), 32'(r));
      chk(req, "proto_err", 32'(proto_err), 32'(perr));
   endtask

   task automatic ror_cyc(input logic [11:0] r);
      @(negedge clk) addr = r; ras_n = 1'b0; oe_n = 1'b0;
      @(negedge clk);
      chk("R5", "dq_oe during refresh", 32'(dq_oe), 32'd0);
      @(negedge clk) ras_n = 1'b1;
      @(negedge clk) report("R5", T_ROR, r, 1'b0);
      chk("R5", "dq_oe", 32'(dq_oe), 32'd0);
      oe_n = 1'b1;
   endtask

   task automatic write_cyc(input logic [11:0] r, input logic [11:0] c, input logic [3:0] d);
      @(negedge clk) addr = r; ras_n = 1'b0;
      @(negedge clk) addr = c; we_n = 1'b0; dq_in = d; cas_n = 1'b0; oe_n = 1'b0;
      @(negedge clk) chk("R3", "dq_oe early write", 32'(dq_oe), 32'd0);
      cas_n = 1'b1; we_n = 1'b1;
      @(negedge clk) ras_n = 1'b1;
      @(negedge clk) report("R3", T_WRITE, r, 1'b0);
      oe_n = 1'b1;
      mdl[widx(r, c)] = d;
   endtask

   task automatic read_cyc(input logic [11:0] r, input logic [11:0] c);
      @(negedge clk) addr = r; ras_n = 1'b0;
      @(negedge clk) addr = c; cas_n = 1'b0; oe_n = 1'b0;
      @(negedge clk) chk("R2", "dq_oe", 32'(dq_oe), 32'd1);
      chk("R2", "dq_out", 32'(dq_out), 32'(mdl[widx(r, c)]));
      cas_n = 1'b1;
      @(negedge clk) chk("R2", "dq_oe held after CAS rise", 32'(dq_oe), 32'd1);
      ras_n = 1'b1;
      @(negedge clk) report("R12", T_READ, r, 1'b0);
      chk("R2", "dq_oe released", 32'(dq_oe), 32'd0);
      oe_n = 1'b1;
   endtask

   task automatic rmw_cyc(input logic [11:0] r, input logic [11:0] c, input logic [3:0] d);
      @(negedge clk) addr = r; ras_n = 1'b0;
      @(negedge clk) addr = c; cas_n = 1'b0; oe_n = 1'b0;
      @(negedge clk) chk("R4", "read part", 32'(dq_out), 32'(mdl[widx(r, c)]));
      oe_n = 1'b1; we_n = 1'b0; dq_in = d;
      @(negedge clk) we_n = 1'b1; cas_n = 1'b1;
      @(negedge clk) ras_n = 1'b1;
      @(negedge clk) report("R4", T_RMW, r, 1'b0);
      mdl[widx(r, c)] = d;
   endtask

   task automatic cbr_cyc(input logic test, input logic [11:0] junk1, input logic [11:0] junk2);
      @(negedge clk) cas_n = 1'b0; we_n = ~test; addr = junk1;
      @(negedge clk) ras_n = 1'b0;
      @(negedge clk) addr = junk2; we_n = 1'b1;
      @(negedge clk) addr = junk1;
      @(negedge clk) ras_n = 1'b1; cas_n = 1'b1;
      @(negedge clk);
      if (test) report("R7", T_TEST, ref_ctr, 1'b0);
      else begin
         report("R6", T_CBR, ref_ctr, 1'b0);
         ref_ctr = ref_ctr + 1'b1;
      end
   endtask

   initial begin
      #(4 * 150000);
      n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      for (int i = 0; i < 64; i++) mdl[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "dq_oe", 32'(dq_oe), 32'd0);
      chk("R1", "dq_out", 32'(dq_out), 32'd0);
      chk("R1", "cyc_valid", 32'(cyc_valid), 32'd0);
      chk("R1", "self_ref", 32'(self_ref), 32'd0);
      chk("R1", "proto_err", 32'(proto_err), 32'd0);

      // table walk
      for (int v = 0; v < NV; v++) begin
         case (VECS[v].op)
            OP_ROR:  ror_cyc(VECS[v].row);
            OP_WR:   write_cyc(VECS[v].row, VECS[v].col, VECS[v].data);
            OP_RD:   read_cyc(VECS[v].row, VECS[v].col);
            OP_RMW:  rmw_cyc(VECS[v].row, VECS[v].col, VECS[v].data);
            OP_CBR:  cbr_cyc(1'b0, VECS[v].row, VECS[v].col);
            default: cbr_cyc(1'b1, VECS[v].row, VECS[v].col);
         endcase
      end

      // R9: OE high mid-read turns bus off at once, low turns it back on
      write_cyc(12'h011, 12'h002, 4'h9);
      @(negedge clk) addr = 12'h011; ras_n = 1'b0;
      @(negedge clk) addr = 12'h002; cas_n = 1'b0; oe_n = 1'b0;
      @(negedge clk) chk("R9", "dq_oe before OE high", 32'(dq_oe), 32'd1);
      oe_n = 1'b1;
      #1 chk("R9", "dq_oe after OE high", 32'(dq_oe), 32'd0);
      @(negedge clk) oe_n = 1'b0;
      #1 chk("R9", "dq_out after OE low", 32'(dq_out), 32'h9);
      cas_n = 1'b1;
      @(negedge clk) ras_n = 1'b1;
      @(negedge clk) report("R2", T_READ, 12'h011, 1'b0);
      oe_n = 1'b1;

      // page mode: two column strobes, two address moves, no violation
      write_cyc(12'h004, 12'h006, 4'hC);
      @(negedge clk) addr = 12'h004; ras_n = 1'b0;
      @(negedge clk) addr = 12'h003; cas_n = 1'b0; oe_n = 1'b0;
      @(negedge clk) chk("R2", "page word 1", 32'(dq_out), 32'(mdl[widx(12'h004, 12'h003)]));
      cas_n = 1'b1; addr = 12'h006;
      @(negedge clk) cas_n = 1'b0;
      @(negedge clk) chk("R2", "page word 2", 32'(dq_out), 32'hC);
      cas_n = 1'b1;
      @(negedge clk) ras_n = 1'b1;
      @(negedge clk) report("R11", T_READ, 12'h004, 1'b0);
      oe_n = 1'b1;

      // R11: two address moves with a single column strobe
      @(negedge clk) addr = 12'h020; ras_n = 1'b0;
      @(negedge clk) addr = 12'h111;
      @(negedge clk) addr = 12'h001; cas_n = 1'b0;
      @(negedge clk) cas_n = 1'b1;
      @(negedge clk) ras_n = 1'b1;
      @(negedge clk) report("R11", T_READ, 12'h020, 1'b1);

      // R8: hidden refresh
      write_cyc(12'h003, 12'h005, 4'h7);
      @(negedge clk) addr = 12'h003; ras_n = 1'b0;
      @(negedge clk) addr = 12'h005; cas_n = 1'b0; oe_n = 1'b0;
      @(negedge clk) chk("R8", "data before hidden", 32'(dq_out), 32'h7);
      ras_n = 1'b1;
      @(negedge clk) report("R8", T_READ, 12'h003, 1'b0);
      chk("R8", "dq_oe across RAS rise", 32'(dq_oe), 32'd1);
      ras_n = 1'b0; addr = 12'hFFF;
      @(negedge clk);
      @(negedge clk) chk("R8", "dq_oe in refresh", 32'(dq_oe), 32'd1);
      chk("R8", "dq_out in refresh", 32'(dq_out), 32'h7);
      ras_n = 1'b1;
      @(negedge clk) report("R8", T_HIDDEN, ref_ctr, 1'b0);
      ref_ctr = ref_ctr + 1'b1;
      chk("R8", "dq_oe after hidden", 32'(dq_oe), 32'd1);
      cas_n = 1'b1;
      @(negedge clk);
      @(negedge clk) chk("R8", "dq_oe after CAS rise", 32'(dq_oe), 32'd0);
      oe_n = 1'b1;

      // R10: self refresh
      @(negedge clk) cas_n = 1'b0;
      @(negedge clk) ras_n = 1'b0;
      repeat (4) @(negedge clk);
      chk("R10", "self_ref early", 32'(self_ref), 32'd0);
      repeat (SELF_THR + 4) @(negedge clk);
      chk("R10", "self_ref held", 32'(self_ref), 32'd1);
      ras_n = 1'b1; cas_n = 1'b1;
      @(negedge clk) report("R10", T_SELF, ref_ctr, 1'b0);
      ref_ctr = ref_ctr + 1'b1;
      chk("R10", "self_ref exit", 32'(self_ref), 32'd0);

      // counter continues after all refresh kinds
      cbr_cyc(1'b0, 12'h0F0, 12'h00F);
      @(negedge clk) chk("R12", "pulse ends", 32'(cyc_valid), 32'd0);

      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule